// File: doc/BRIEF.md
# Twin-Predicated Register Move Sequencer

This block turns one vectorised register move into a stream of scalar move micro-ops. A move is described by a source base register and a destination base register. Each side has an "is vector" flag and its own predicate mask. A vector length sets how many elements take part. The block keeps two element cursors, one per side. Before each move, a vector cursor skips the elements its predicate disables. The block then issues one move that pairs the current source element with the current destination element. After the move, each vector cursor steps on by one. A scalar side stays on its base register and its predicate has no effect.

This one walk produces several distinct operations from a single move instruction:

- plain vector copy
- gather, which packs the enabled source elements together
- scatter, which spreads source elements into the enabled destination slots
- gather and scatter combined
- splat and sparse splat, which replicate a scalar
- extract, from a vector into a scalar
- insert, from a scalar into a vector

Moves leave through a valid/ready handshake, one per cycle at most. The register file that carries out each move sits downstream. A single-cycle done pulse marks the end of the sequence.

Top module: `twin_pred_mv_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `mv_valid` and `done` are all low.
- R2: A `start` is taken only while `busy` is low. Taking it latches every operand input and raises `busy` in the following cycle. A `start` raised while `busy` is high has no effect on the moves of the sequence already running.
- R3: When the source is a vector, the source cursor skips every element whose bit in `src_pred` (bit k belongs to element k) is 0. When the destination is a vector, the destination cursor does the same with `dst_pred`. Each move pairs the two current cursors, and after the move each vector cursor advances by one.
- R4: When an operand is scalar, its cursor stays at element 0, so its index is always its base register, and its predicate input is ignored. A scalar source with a vector destination therefore repeats the scalar into every enabled destination element.
- R5: The sequence ends with no further move as soon as either cursor reaches the vector length, or a vector cursor finds no enabled element below the vector length. All pairs the walk defines are issued, in order, before the end.
- R6: `done` is high for exactly one cycle. It rises in the cycle after the sequence ends, and in that cycle `busy` and `mv_valid` are low.
- R7: When both operands are scalar and the vector length is at least 1, exactly one move (source base to destination base) is issued.
- R8: While `mv_valid` is high and `mv_ready` is low, `mv_valid`, `mv_src` and `mv_dst` hold their values into the next cycle.
- R9: A vector length of 0 gives no move and a done pulse. A vector length above `VL_MAX` is treated as `VL_MAX`.
- R10: A register index is the base plus the element number, modulo 2^`REG_W`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin a sequence; taken only while idle |
| src_base | input | REG_W | Source base register index |
| dst_base | input | REG_W | Destination base register index |
| src_vec | input | 1 | Source is a vector when 1 |
| dst_vec | input | 1 | Destination is a vector when 1 |
| src_pred | input | VL_MAX | Source predicate, bit k enables element k |
| dst_pred | input | VL_MAX | Destination predicate, bit k enables element k |
| vl | input | $clog2(VL_MAX+1) | Vector length, clamped to VL_MAX |
| mv_valid | output | 1 | A move micro-op is presented |
| mv_ready | input | 1 | Downstream accepts the presented move |
| mv_src | output | REG_W | Source register of the move |
| mv_dst | output | REG_W | Destination register of the move |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Single-cycle end-of-sequence pulse |

## Verification
The bench builds the block with `VL_MAX` = 8 and `REG_W` = 5. This makes the vl input 4 bits wide, so a length of 12 can be driven and the clamp to 8 is exercised. With five-bit indices, a base of 30 pushes vector elements past 31, so the wrap back to 0 is observed. Eight elements are also enough for sparse patterns in which the two predicates disagree. In those cases one cursor runs out before the other, which exercises the early ending.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
   typedef enum logic [0:0] {
      TPM_IDLE = 1'b0,
      TPM_RUN  = 1'b1
   } tpm_state_e;
endpackage

// File: rtl/tpm_find_first.sv
module tpm_find_first #(
   parameter int N     = 8,
   parameter int OUT_W = 4
) (
   input  logic [N-1:0]     vec,
   output logic             hit,
   output logic [OUT_W-1:0] idx
);
   always_comb begin
      hit = |vec;
      idx = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (vec[k]) idx = OUT_W'(k);
      end
   end
endmodule

// File: rtl/tpm_cursor.sv
module tpm_cursor #(
   parameter int VL_MAX = 8,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              vec_in,
   input  logic [VL_MAX-1:0] pred_in,
   input  logic              adv,
   input  logic [CNT_W-1:0]  vl_eff,
   output logic              found,
   output logic [CNT_W-1:0]  pos
);
   logic [CNT_W-1:0]  cur;
   logic [VL_MAX-1:0] pred_q;
   logic              vec_q;
   logic [VL_MAX-1:0] window;
   logic              any_hit;
   logic [CNT_W-1:0]  first_idx;

   // elements enabled, at or past the cursor, and inside the vector length
   for (genvar g = 0; g < VL_MAX; g++) begin : g_win
      localparam logic [CNT_W-1:0] GI = CNT_W'(g);
      assign window[g] = pred_q[g] && (GI >= cur) && (GI < vl_eff);
   end

   tpm_find_first #(.N(VL_MAX), .OUT_W(CNT_W)) u_first (
      .vec (window),
      .hit (any_hit),
      .idx (first_idx)
   );

   assign found = vec_q ? any_hit   : (cur < vl_eff);
   assign pos   = vec_q ? first_idx : cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur    <= '0;
         pred_q <= '0;
         vec_q  <= 1'b0;
      end else if (load) begin
         cur    <= '0;
         pred_q <= pred_in;
         vec_q  <= vec_in;
      end else if (adv && vec_q) begin
         cur <= pos + CNT_W'(1);
      end
   end
endmodule

// File: rtl/twin_pred_mv_seq.sv
module twin_pred_mv_seq #(
   parameter int VL_MAX = 8,
   parameter int REG_W  = 5,
   localparam int CNT_W = $clog2(VL_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [REG_W-1:0]  src_base,
   input  logic [REG_W-1:0]  dst_base,
   input  logic              src_vec,
   input  logic              dst_vec,
   input  logic [VL_MAX-1:0] src_pred,
   input  logic [VL_MAX-1:0] dst_pred,
   input  logic [CNT_W-1:0]  vl,
   output logic              mv_valid,
   input  logic              mv_ready,
   output logic [REG_W-1:0]  mv_src,
   output logic [REG_W-1:0]  mv_dst,
   output logic              busy,
   output logic              done
);
   import tpm_pkg::*;

   localparam logic [CNT_W-1:0] VL_CAP = CNT_W'(VL_MAX);

   if (VL_MAX < 1) begin : g_bad_len
      $error("VL_MAX must be at least 1");
   end
   if (REG_W < 1) begin : g_bad_regw
      $error("REG_W must be at least 1");
   end

   tpm_state_e       state;
   logic [REG_W-1:0] src_base_q, dst_base_q;
   logic [CNT_W-1:0] vl_q, vl_in;
   logic             last_q, done_q;
   logic             accept, fire, finish, both_scalar;
   logic             s_found, d_found;
   logic [CNT_W-1:0] s_pos, d_pos;
   logic             src_vec_q, dst_vec_q;

   assign vl_in  = (vl > VL_CAP) ? VL_CAP : vl;
   assign accept = start && (state == TPM_IDLE);

   tpm_cursor #(.VL_MAX(VL_MAX), .CNT_W(CNT_W)) u_src_cur (
      .clk (clk), .rst_n (rst_n), .load (accept), .vec_in (src_vec),
      .pred_in (src_pred), .adv (fire), .vl_eff (vl_q),
      .found (s_found), .pos (s_pos)
   );

   tpm_cursor #(.VL_MAX(VL_MAX), .CNT_W(CNT_W)) u_dst_cur (
      .clk (clk), .rst_n (rst_n), .load (accept), .vec_in (dst_vec),
      .pred_in (dst_pred), .adv (fire), .vl_eff (vl_q),
      .found (d_found), .pos (d_pos)
   );

   assign both_scalar = !src_vec_q && !dst_vec_q;
   assign finish      = last_q || !s_found || !d_found;
   assign mv_valid    = (state == TPM_RUN) && !finish;
   assign fire        = mv_valid && mv_ready;
   assign mv_src      = src_base_q + REG_W'(s_pos);
   assign mv_dst      = dst_base_q + REG_W'(d_pos);
   assign busy        = (state == TPM_RUN);
   assign done        = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= TPM_IDLE;
         src_base_q <= '0;
         dst_base_q <= '0;
         vl_q       <= '0;
         src_vec_q  <= 1'b0;
         dst_vec_q  <= 1'b0;
         last_q     <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            state      <= TPM_RUN;
            src_base_q <= src_base;
            dst_base_q <= dst_base;
            vl_q       <= vl_in;
            src_vec_q  <= src_vec;
            dst_vec_q  <= dst_vec;
            last_q     <= 1'b0;
         end else if (state == TPM_RUN) begin
            if (finish) begin
               state  <= TPM_IDLE;
               done_q <= 1'b1;
            end else if (fire && both_scalar) begin
               last_q <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/tpm_chk.sv
module tpm_chk #(
   parameter int VL_MAX = 8,
   parameter int REG_W  = 5,
   localparam int CNT_W = $clog2(VL_MAX + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             src_vec,
   input logic             dst_vec,
   input logic             mv_valid,
   input logic             mv_ready,
   input logic [REG_W-1:0] mv_src,
   input logic [REG_W-1:0] mv_dst,
   input logic             busy,
   input logic             done
);
   logic both_sc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) both_sc_q <= 1'b0;
      else if (start && !busy) both_sc_q <= !src_vec && !dst_vec;
   end

   // R2
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy);

   // R2
   valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mv_valid |-> busy);

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !mv_valid));

   // R7
   single_scalar_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mv_valid && mv_ready && both_sc_q |=> !mv_valid);

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mv_valid && !mv_ready |=> mv_valid && $stable(mv_src) && $stable(mv_dst));
endmodule

bind twin_pred_mv_seq tpm_chk #(.VL_MAX(VL_MAX), .REG_W(REG_W)) u_chk (
   .clk (clk), .rst_n (rst_n), .start (start), .src_vec (src_vec),
   .dst_vec (dst_vec), .mv_valid (mv_valid), .mv_ready (mv_ready),
   .mv_src (mv_src), .mv_dst (mv_dst), .busy (busy), .done (done)
);

// File: tb/twin_pred_mv_seq_bench.sv
module twin_pred_mv_seq_bench;
   localparam int VL_MAX = 8;
   localparam int REG_W  = 5;
   localparam int CNT_W  = $clog2(VL_MAX + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [REG_W-1:0]  src_base = '0, dst_base = '0;
   logic              src_vec = 1'b0, dst_vec = 1'b0;
   logic [VL_MAX-1:0] src_pred = '0, dst_pred = '0;
   logic [CNT_W-1:0]  vl = '0;
   logic              mv_valid, mv_ready = 1'b0;
   logic [REG_W-1:0]  mv_src, mv_dst;
   logic              busy, done;

   int checks = 0;
   int errors = 0;
   logic [2*REG_W-1:0] exp_q[$];
   string  cur_tag = "R1";
   int     ready_mode = 0;
   logic [15:0] lfsr = 16'hACE1;
   bit     done_seen = 0;
   bit     prev_done = 0;
   bit     prev_stall = 0;
   logic [REG_W-1:0] prev_src, prev_dst;
   bit     monitor_on = 0;

   always #5 clk = ~clk;

   twin_pred_mv_seq #(.VL_MAX(VL_MAX), .REG_W(REG_W)) u_twin_pred_mv_seq (
      .clk (clk), .rst_n (rst_n), .start (start), .src_base (src_base),
      .dst_base (dst_base), .src_vec (src_vec), .dst_vec (dst_vec),
      .src_pred (src_pred), .dst_pred (dst_pred), .vl (vl),
      .mv_valid (mv_valid), .mv_ready (mv_ready), .mv_src (mv_src),
      .mv_dst (mv_dst), .busy (busy), .done (done)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // reference walk of the two cursors, written from the requirements
   task automatic build_expect(input int sb, input int db, input bit sv, input bit dv,
                               input logic [VL_MAX-1:0] sp, input logic [VL_MAX-1:0] dp,
                               input int len);
      int vle = (len > VL_MAX) ? VL_MAX : len;
      int i = 0;
      int j = 0;
      logic [REG_W-1:0] s, d;
      forever begin
         if (sv) while (i < vle && !sp[i]) i++;
         if (dv) while (j < vle && !dp[j]) j++;
         if (i >= vle || j >= vle) break;
         s = REG_W'(sb + i);
         d = REG_W'(db + j);
         exp_q.push_back({s, d});
         if (!sv && !dv) break;
         if (sv) i++;
         if (dv) j++;
      end
   endtask

   task automatic run_case(input string tag, input int sb, input int db,
                           input bit sv, input bit dv,
                           input logic [VL_MAX-1:0] sp, input logic [VL_MAX-1:0] dp,
                           input int len, input int rmode, input bit poke);
      int n_exp;
      @(negedge clk);
      while (busy) @(negedge clk);
      cur_tag = tag;
      ready_mode = rmode;
      exp_q.delete();
      build_expect(sb, db, sv, dv, sp, dp, len);
      n_exp = exp_q.size();
      done_seen = 0;
      src_base = REG_W'(sb); dst_base = REG_W'(db);
      src_vec = sv; dst_vec = dv; src_pred = sp; dst_pred = dp;
      vl = CNT_W'(len);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         @(negedge clk);
         chk(busy == 1'b1, "R2", "busy before ignored start", busy, 1);
         src_base = 5'd17; dst_base = 5'd9; src_vec = 1'b0; dst_vec = 1'b1;
         src_pred = '0; dst_pred = 8'h0F; vl = 4'd3;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done_seen) @(negedge clk);
      chk(exp_q.size() == 0, tag, "moves left unissued", exp_q.size(), 0);
      $display("case %s: %0d moves expected", tag, n_exp);
   endtask

   // monitor: drives ready, then samples away from the clock edge
   always @(negedge clk) begin
      if (ready_mode == 0) mv_ready <= 1'b1;
      else mv_ready <= lfsr[0] & lfsr[3];
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      #1;
      if (monitor_on) begin
         if (prev_stall) begin
            // R8
            chk(mv_valid == 1'b1, "R8", "valid dropped while stalled", mv_valid, 1);
            chk(mv_src == prev_src && mv_dst == prev_dst, "R8",
                "indices changed while stalled", {mv_src, mv_dst}, {prev_src, prev_dst});
         end
         if (mv_valid && mv_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, cur_tag, "unexpected move src/dst", {mv_src, mv_dst}, 0);
            end else begin
               logic [2*REG_W-1:0] e;
               e = exp_q.pop_front();
               chk({mv_src, mv_dst} == e, cur_tag, "move src/dst",
                   {mv_src, mv_dst}, e);
            end
         end
         prev_stall = mv_valid && !mv_ready;
         prev_src = mv_src;
         prev_dst = mv_dst;
         if (done) begin
            // R6
            chk(!prev_done, "R6", "done longer than one cycle", 2, 1);
            chk(!busy && !mv_valid, "R6", "busy/valid during done", {busy, mv_valid}, 0);
            done_seen = 1;
         end
         prev_done = done;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #2;
      // R1
      chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
      chk(mv_valid == 1'b0, "R1", "valid in reset", mv_valid, 0);
      chk(done == 1'b0, "R1", "done in reset", done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      chk(busy == 1'b0 && mv_valid == 1'b0 && done == 1'b0, "R1",
          "idle after reset", {busy, mv_valid, done}, 0);
      monitor_on = 1;

      // R3 plain copy, vector to vector
      run_case("R3", 4, 12, 1, 1, 8'hFF, 8'hFF, 8, 0, 0);
      // R3 gather
      run_case("R3", 0, 16, 1, 1, 8'b1011_0010, 8'hFF, 8, 0, 0);
      // R3 scatter
      run_case("R3", 8, 20, 1, 1, 8'hFF, 8'b0101_1001, 8, 0, 0);
      // R3 gather and scatter together, with stalls
      run_case("R3", 2, 10, 1, 1, 8'b1100_1010, 8'b0011_0111, 8, 1, 0);
      // R4 splat, source predicate ignored
      run_case("R4", 5, 8, 0, 1, 8'h00, 8'hFF, 6, 0, 0);
      // R4 sparse splat
      run_case("R4", 7, 1, 0, 1, 8'h55, 8'b1001_0110, 8, 1, 0);
      // R4 extract, destination predicate ignored
      run_case("R4", 3, 25, 1, 0, 8'b0010_0000, 8'h00, 8, 0, 0);
      // R4 insert
      run_case("R4", 6, 14, 0, 1, 8'h00, 8'b0000_1000, 8, 0, 0);
      // R5 empty source predicate ends with no move
      run_case("R5", 1, 2, 1, 1, 8'h00, 8'hFF, 8, 0, 0);
      // R5 destination runs out first
      run_case("R5", 0, 8, 1, 1, 8'hFF, 8'b0000_0110, 8, 0, 0);
      // R7 both scalar
      run_case("R7", 9, 11, 0, 0, 8'h00, 8'h00, 5, 1, 0);
      // R9 zero length, both scalar and vector
      run_case("R9", 9, 11, 0, 0, 8'hFF, 8'hFF, 0, 0, 0);
      run_case("R9", 9, 11, 1, 1, 8'hFF, 8'hFF, 0, 0, 0);
      // R9 length above VL_MAX clamps
      run_case("R9", 0, 16, 1, 1, 8'hFF, 8'hFF, 12, 0, 0);
      // R10 index wrap past the top register
      run_case("R10", 30, 28, 1, 1, 8'hFF, 8'b1110_0011, 8, 0, 0);
      // R2 start during a running sequence is ignored; R8 stalls
      run_case("R2", 3, 19, 1, 1, 8'hFF, 8'hFF, 8, 1, 1);

      repeat (3) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule